// File: doc/BRIEF.md
# Token Bucket Transmit Rate Limiter

This block sits on the transmit side of a packet link and slows the average rate of data beats. It holds a bucket of byte credits. While the limiter is switched on, a fixed number of credits is added once per refill period, and that period is counted in bus clock cycles. A beat that carries N bytes passes only if the bucket holds at least N credits. If it does not, the beat is held back, and the block flags that an idle control word goes out in that cycle in place of data.

The upstream scheduler presents one beat per cycle on a valid/ready pair. `req_bytes` gives the beat's size, from 0 to 64 bytes. A beat transfers in a cycle where both `req_valid` and `req_ready` are high. `req_ready` does not depend on `req_valid`, so the source may look at it before it commits. A source that sees `req_ready` low must hold its beat and offer it again later. In every cycle where a beat is withheld, `idle_ins` tells the framing logic to emit an idle.

The two settings are copied into the block when `cfg_en` rises, and later changes on those pins are ignored until the limiter is switched off again. The live bucket level is available on `bucket_level`.

Top module: `tx_rate_limiter`

## Requirements
- R1: While `rst_n` is low, `bucket_level` is 64 and the refill cycle count restarts.
- R2: While the limiter is off, `req_ready` is 1 for every request. One cycle later `bucket_level` equals the cap of the settings then present on the pins, with no deduction for the beats that passed.
- R3: While the limiter is on, `req_ready` is 1 exactly when `bucket_level` is at least `req_bytes`. The bytes of an accepted beat leave the bucket at that same clock edge.
- R4: `idle_ins` is 1 exactly in the cycles where `req_valid` is 1 and `req_ready` is 0.
- R5: Refills come every `cfg_intv` enabled cycles, counted from the edge at which the limiter turns on. The first refill lands at the edge that closes the `cfg_intv`-th enabled cycle. A setting of 0 means 256 cycles.
- R6: The cap is the larger of 4 × tokens-per-refill and 64. A refill never lifts the level above the cap.
- R7: Both settings are sampled at the edge where the limiter turns on. Changes on `cfg_intv` and `cfg_tokens` while it stays on change neither the refill size nor the refill timing.
- R8: With a latched tokens-per-refill of 0, an enabled limiter holds `req_ready` at 0 for every request, including zero-byte beats.
- R9: When a beat is accepted in the same cycle as a refill, the new level is the old level minus the beat's bytes plus the refill.
- R10: While the limiter is on, a cycle with no accepted beat and no refill leaves `bucket_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Limiter on when high |
| cfg_intv | input | 8 | Refill period in cycles (0 means 256) |
| cfg_tokens | input | 12 | Byte credits added per refill; 0 is illegal |
| req_valid | input | 1 | A data beat is offered |
| req_bytes | input | 7 | Byte count of the offered beat, 0 to 64 |
| req_ready | output | 1 | Beat may transfer this cycle |
| idle_ins | output | 1 | Insert an idle control word this cycle |
| bucket_level | output | 14 | Current credit count |

## Verification
The assertions check four things on every cycle. Idles are flagged only for withheld beats. An off limiter never withholds. A zero refill size blocks all traffic. The level never rises above the cap, drops by exactly the accepted bytes when no refill coincides, and stays put when nothing happens. Refill timing, the 256-cycle meaning of a zero period, the freezing of settings and the value of the cap are shown only by the bench's scenarios, which track the expected level cycle by cycle.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // Default widths and limits for the rate limiter
  localparam int RL_INTV_W    = 8;   // refill period counter width
  localparam int RL_TOK_W     = 12;  // tokens added per refill
  localparam int RL_BEAT_MAX  = 64;  // widest beat in bytes
  localparam int RL_CAP_SHIFT = 2;   // cap holds 2**shift refills
endpackage

// File: rtl/rl_cfg_hold.sv
module rl_cfg_hold #(
  parameter int INTV_W    = 8,
  parameter int TOK_W     = 12,
  parameter int CAP_SHIFT = 2,
  parameter int BEAT_MAX  = 64,
  parameter int LVL_W     = TOK_W + CAP_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [INTV_W-1:0] cfg_intv,
  input  logic [TOK_W-1:0]  cfg_tokens,
  output logic              en_q,
  output logic [INTV_W-1:0] hold_intv,
  output logic [TOK_W-1:0]  hold_tokens,
  output logic [LVL_W-1:0]  cap_live,
  output logic [LVL_W-1:0]  cap_held,
  output logic              tok_zero
);
  function automatic logic [LVL_W-1:0] cap_of(input logic [TOK_W-1:0] t);
    logic [LVL_W-1:0] scaled;
    scaled = LVL_W'(t) << CAP_SHIFT;
    return (scaled > LVL_W'(BEAT_MAX)) ? scaled : LVL_W'(BEAT_MAX);
  endfunction

  // Shadow copies track the pins while off and freeze once the enable is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      hold_intv   <= '0;
      hold_tokens <= '0;
    end else begin
      en_q <= cfg_en;
      if (!en_q) begin
        hold_intv   <= cfg_intv;
        hold_tokens <= cfg_tokens;
      end
    end
  end

  always_comb begin
    cap_live = cap_of(cfg_tokens);
    cap_held = cap_of(hold_tokens);
    tok_zero = (hold_tokens == '0);
  end
endmodule

// File: rtl/rl_refill_timer.sv
module rl_refill_timer #(
  parameter int INTV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INTV_W-1:0] period,
  output logic              tick
);
  logic [INTV_W-1:0] cnt;
  logic [INTV_W-1:0] last;

  // A period of zero wraps to the full counter range
  assign last = period - INTV_W'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + INTV_W'(1);
  end
endmodule

// File: rtl/rl_bucket.sv
module rl_bucket #(
  parameter int TOK_W    = 12,
  parameter int LVL_W    = 14,
  parameter int BYTE_W   = 7,
  parameter int BEAT_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tok_zero,
  input  logic              tick,
  input  logic [TOK_W-1:0]  refill,
  input  logic [LVL_W-1:0]  cap_live,
  input  logic [LVL_W-1:0]  cap_held,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_bytes,
  output logic              req_ready,
  output logic              idle_ins,
  output logic [LVL_W-1:0]  level
);
  localparam int SUM_W = LVL_W + 1;

  logic             take;
  logic [SUM_W-1:0] sum;
  logic [LVL_W-1:0] level_nx;

  always_comb begin
    req_ready = !run || (!tok_zero && (level >= LVL_W'(req_bytes)));
    take      = req_valid && req_ready;
    idle_ins  = req_valid && !req_ready;
    sum       = SUM_W'(level)
              - (take ? SUM_W'(req_bytes) : '0)
              + (tick ? SUM_W'(refill)    : '0);
    level_nx  = (sum > SUM_W'(cap_held)) ? cap_held : sum[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= LVL_W'(BEAT_MAX);
    else if (!run) level <= cap_live;
    else           level <= level_nx;
  end
endmodule

// File: rtl/tx_rate_limiter.sv
module tx_rate_limiter
  import rl_pkg::*;
#(
  parameter int INTV_W    = RL_INTV_W,
  parameter int TOK_W     = RL_TOK_W,
  parameter int BEAT_MAX  = RL_BEAT_MAX,
  parameter int CAP_SHIFT = RL_CAP_SHIFT,
  parameter int BYTE_W    = $clog2(BEAT_MAX + 1),
  parameter int LVL_W     = TOK_W + CAP_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [INTV_W-1:0] cfg_intv,
  input  logic [TOK_W-1:0]  cfg_tokens,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_bytes,
  output logic              req_ready,
  output logic              idle_ins,
  output logic [LVL_W-1:0]  bucket_level
);
  logic              en_q;
  logic [INTV_W-1:0] hold_intv;
  logic [TOK_W-1:0]  hold_tokens;
  logic [LVL_W-1:0]  cap_live;
  logic [LVL_W-1:0]  cap_held;
  logic              tok_zero;
  logic              tick;

  rl_cfg_hold #(
    .INTV_W(INTV_W), .TOK_W(TOK_W), .CAP_SHIFT(CAP_SHIFT),
    .BEAT_MAX(BEAT_MAX), .LVL_W(LVL_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_intv(cfg_intv),
    .cfg_tokens(cfg_tokens), .en_q(en_q), .hold_intv(hold_intv),
    .hold_tokens(hold_tokens), .cap_live(cap_live), .cap_held(cap_held),
    .tok_zero(tok_zero)
  );

  rl_refill_timer #(.INTV_W(INTV_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(en_q), .period(hold_intv), .tick(tick)
  );

  rl_bucket #(
    .TOK_W(TOK_W), .LVL_W(LVL_W), .BYTE_W(BYTE_W), .BEAT_MAX(BEAT_MAX)
  ) i_bucket (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tok_zero(tok_zero), .tick(tick),
    .refill(hold_tokens), .cap_live(cap_live), .cap_held(cap_held),
    .req_valid(req_valid), .req_bytes(req_bytes), .req_ready(req_ready),
    .idle_ins(idle_ins), .level(bucket_level)
  );
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
  parameter int LVL_W  = 14,
  parameter int BYTE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [BYTE_W-1:0] req_bytes,
  input logic              req_ready,
  input logic              idle_ins,
  input logic [LVL_W-1:0]  bucket_level,
  input logic              en_q,
  input logic              tick,
  input logic              tok_zero,
  input logic [LVL_W-1:0]  cap_held
);
  // R4
  idle_only_withheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ins |-> (req_valid && !req_ready));

  // R2
  off_passes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> req_ready);

  // R8
  zero_refill_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tok_zero) |-> !req_ready);

  // R6
  level_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (bucket_level <= cap_held));

  // R3
  debit_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && req_valid && req_ready && !tick) |=>
      (bucket_level == $past(bucket_level) - LVL_W'($past(req_bytes))));

  // R10
  idle_level_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !req_valid && !tick) |=> $stable(bucket_level));
endmodule

bind tx_rate_limiter rl_checker #(.LVL_W(LVL_W), .BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bytes(req_bytes),
  .req_ready(req_ready), .idle_ins(idle_ins), .bucket_level(bucket_level),
  .en_q(en_q), .tick(tick), .tok_zero(tok_zero), .cap_held(cap_held)
);

// File: tb/test_tx_rate_limiter.sv
module test_tx_rate_limiter;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        v;
    logic [6:0]  b;
    logic        r;
    logic [13:0] l;
  } vec_t;

  // Settings for the walk: period 4, refill 20, cap 80 (R5, R6, R9)
  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 7'd64, 1'b1, 14'd16}, '{1'b1, 7'd32, 1'b0, 14'd16},
    '{1'b1, 7'd16, 1'b1, 14'd0},  '{1'b0, 7'd0,  1'b1, 14'd20},
    '{1'b1, 7'd20, 1'b1, 14'd0},  '{1'b1, 7'd1,  1'b0, 14'd0},
    '{1'b1, 7'd0,  1'b1, 14'd0},  '{1'b1, 7'd8,  1'b0, 14'd20},
    '{1'b0, 7'd0,  1'b1, 14'd20}, '{1'b0, 7'd0,  1'b1, 14'd20},
    '{1'b0, 7'd0,  1'b1, 14'd20}, '{1'b0, 7'd0,  1'b1, 14'd40},
    '{1'b0, 7'd0,  1'b1, 14'd40}, '{1'b0, 7'd0,  1'b1, 14'd40},
    '{1'b0, 7'd0,  1'b1, 14'd40}, '{1'b0, 7'd0,  1'b1, 14'd60},
    '{1'b0, 7'd0,  1'b1, 14'd60}, '{1'b0, 7'd0,  1'b1, 14'd60},
    '{1'b0, 7'd0,  1'b1, 14'd60}, '{1'b0, 7'd0,  1'b1, 14'd80},
    '{1'b0, 7'd0,  1'b1, 14'd80}, '{1'b0, 7'd0,  1'b1, 14'd80},
    '{1'b0, 7'd0,  1'b1, 14'd80}, '{1'b0, 7'd0,  1'b1, 14'd80},
    '{1'b1, 7'd64, 1'b1, 14'd16}, '{1'b1, 7'd16, 1'b1, 14'd0},
    '{1'b1, 7'd64, 1'b0, 14'd0},  '{1'b1, 7'd64, 1'b0, 14'd20},
    '{1'b1, 7'd10, 1'b1, 14'd10}, '{1'b0, 7'd0,  1'b1, 14'd10},
    '{1'b0, 7'd0,  1'b1, 14'd10}, '{1'b1, 7'd10, 1'b1, 14'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en;
  logic [7:0]  cfg_intv;
  logic [11:0] cfg_tokens;
  logic        req_valid;
  logic [6:0]  req_bytes;
  logic        req_ready;
  logic        idle_ins;
  logic [13:0] bucket_level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P / 2) clk = ~clk;

  tx_rate_limiter i_tx_rate_limiter (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_intv(cfg_intv),
    .cfg_tokens(cfg_tokens), .req_valid(req_valid), .req_bytes(req_bytes),
    .req_ready(req_ready), .idle_ins(idle_ins), .bucket_level(bucket_level)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check handshake, then the level after the rise
  task automatic beat(input string req, input logic v, input int b,
                      input logic exp_r, input int exp_l);
    @(negedge clk);
    req_valid = v;
    req_bytes = 7'(b);
    #1;
    check(req, "req_ready", int'(req_ready), int'(exp_r));
    check("R4", "idle_ins", int'(idle_ins), int'(v && !exp_r));
    @(posedge clk);
    #1;
    check(req, "bucket_level", int'(bucket_level), exp_l);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_intv = '0; cfg_tokens = '0;
    req_valid = 1'b0; req_bytes = '0;
    #(CLK_P * 2 + 1);
    // R1: reset level
    check("R1", "bucket_level in reset", int'(bucket_level), 64);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_intv = 8'd4; cfg_tokens = 12'd20;

    // R2: off limiter passes a full beat and holds level at cap(20)=80
    beat("R2", 1'b1, 64, 1'b1, 80);
    beat("R2", 1'b1, 64, 1'b1, 80);

    // Turn on; this cycle still counts as off
    cfg_en = 1'b1;
    beat("R2", 1'b0, 0, 1'b1, 80);
    // R7: later pin changes must not alter period 4 or refill 20
    cfg_intv = 8'd9; cfg_tokens = 12'd1000;

    for (int k = 0; k < NV; k++)
      beat((k >= 28) ? "R9" : (k >= 23 ? "R6" : "R3"),
           TBL[k].v, int'(TBL[k].b), TBL[k].r, int'(TBL[k].l));

    // R7: turn off; first cycle still on, level steady at 20
    cfg_en = 1'b0;
    beat("R10", 1'b0, 0, 1'b1, 20);
    // R2: now off, cap of live 1000 tokens is 4000
    beat("R2", 1'b1, 64, 1'b1, 4000);

    // R8: zero refill size
    cfg_tokens = 12'd0; cfg_intv = 8'd4;
    beat("R6", 1'b0, 0, 1'b1, 64);
    cfg_en = 1'b1;
    beat("R8", 1'b0, 0, 1'b1, 64);
    for (int k = 0; k < 4; k++) beat("R8", 1'b1, 1, 1'b0, 64);
    beat("R8", 1'b1, 0, 1'b0, 64);

    // R5: period setting of 0 means 256 cycles
    cfg_en = 1'b0; cfg_tokens = 12'd5; cfg_intv = 8'd0;
    beat("R8", 1'b0, 0, 1'b0, 64);
    beat("R2", 1'b0, 0, 1'b1, 64);
    cfg_en = 1'b1;
    beat("R2", 1'b0, 0, 1'b1, 64);
    beat("R3", 1'b1, 64, 1'b1, 0);
    for (int k = 2; k <= 256; k++)
      beat("R5", 1'b0, 0, 1'b1, (k == 256) ? 5 : 0);
    beat("R3", 1'b1, 5, 1'b1, 0);
    beat("R3", 1'b1, 1, 1'b0, 0);

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "bucket_level after reset", int'(bucket_level), 64);
    check("R1", "req_ready after reset", int'(req_ready), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule